// File: doc/BRIEF.md
# SPI Flash Register-Driven Transfer Engine

This block runs one single-bit SPI flash transaction that software has built up in a small byte-wide register window. Software loads an instruction byte, up to three address bytes and up to four data bytes. It then writes a control byte that sets the shape of the transaction (address on or off, direction, data length, target chip select) and starts it. The engine clocks the bytes out on MOSI in SPI mode 0 and captures MISO into the data registers when the transaction is a read. Software polls the control byte until its busy flag drops.

SCK runs at half the system clock and has no divider. One bit takes two clock cycles, low then high. A second register holds one active-low bit per chip select. A cleared bit keeps that select asserted between transactions, so software can chain several short transactions into one longer flash command. The fast-read instruction 0x0B is recognised and gets one dummy byte of zeros after its address. Because of this, a read needs no dummy handling in software.

Top module: `spi_uma_engine`

## Requirements
- R1: After reset the control byte reads 0x00, the hold register reads 0x0F, all four `cs_n` are high, and `sck` and `mosi` are low.
- R2: The registers sit at fixed byte offsets: instruction at 0x16; address bytes at 0x17, 0x18 and 0x19 (least significant first); data bytes at 0x1A to 0x1D; control at 0x1E; hold at 0x1F. Each one reads back what was last written to it.
- R3: The control byte packs the data count in bits [2:0], address enable in bit 3, write in bit 4 (1 = data out, 0 = data in), chip select in bits [6:5], and go/busy in bit 7. Writing bit 7 as 1 while idle starts a transaction of B bytes. Bit 7 then reads 1 for exactly 16*B+1 cycles, and afterwards the control byte reads back its lower seven bits unchanged.
- R4: Bytes go out in this order: the instruction, then the address bytes with the most significant (0x19) first when address is enabled, then the data bytes starting at 0x1A. Each byte goes MSB first. MOSI changes only while SCK is low and holds steady across each rising edge.
- R5: In write mode the data bytes are sent from the data registers. In read mode MOSI is 0 during the data phase, and the bits sampled on MISO at the rising SCK edges are stored, MSB first, into data registers 0x1A onward. Data registers beyond the count are left untouched.
- R6: When the instruction is 0x0B, one byte of zeros is inserted after the address phase and before the data phase. It is not stored.
- R7: A data count of 5, 6 or 7 acts as 4. A count of 0 leaves out the data phase.
- R8: The selected `cs_n` falls one cycle before the first rising SCK edge and rises one cycle after the final falling edge. No other unheld chip select goes low.
- R9: A 0 in hold bit i (i = 0..3) keeps `cs_n[i]` low whether or not a transaction is running. Hold bits 7:4 always read 0.
- R10: While a transaction runs, writes to the instruction, address, data and control registers have no effect. The hold register can still be written.
- R11: SCK is low while idle. During a transaction it toggles every cycle, giving exactly 8*B rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the SCK source |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on `reg_addr`) |
| miso | input | 1 | Serial data from the flash |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the flash |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The bench checks the byte order on MOSI against address enabled and disabled, write and read direction, and the fast-read instruction. A design that reverses the address bytes, or that skips or keeps the dummy byte, produces a stream that does not match. Read data is supplied by a modelled flash, so a capture that is off by one bit or one byte shows up as a wrong data register value, and so does a capture that writes past the count. The bench also measures the chip-select window relative to the first and last SCK edges and the exact busy length, which exposes an extra or a missing setup or tail cycle. Finally, it writes registers in the middle of a transaction and checks that nothing changed, including that the transaction did not restart.

// File: rtl/spi_uma_pkg.sv
package spi_uma_pkg;

    localparam int UMA_ADDR_W  = 5;
    localparam int UMA_NUM_CS  = 4;
    localparam int UMA_ADDR_BY = 3;
    localparam int UMA_DATA_BY = 4;

    localparam logic [4:0] REG_OPC  = 5'h16;
    localparam logic [4:0] REG_AB0  = 5'h17;
    localparam logic [4:0] REG_DB0  = 5'h1A;
    localparam logic [4:0] REG_CTRL = 5'h1E;
    localparam logic [4:0] REG_HOLD = 5'h1F;

    localparam logic [7:0] OPC_FAST_READ = 8'h0B;

    // Field layout of the control byte, MSB first.
    typedef struct packed {
        logic       go;
        logic [1:0] sel;
        logic       wr;
        logic       addr_en;
        logic [2:0] cnt;
    } uma_ctrl_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SHIFT = 2'd1,
        PH_TAIL  = 2'd2
    } uma_phase_t;

    function automatic logic [2:0] eff_count(input logic [2:0] c, input logic [2:0] lim);
        return (c > lim) ? lim : c;
    endfunction

endpackage

// File: rtl/uma_regs.sv
module uma_regs
    import spi_uma_pkg::*;
#(
    parameter int AW  = UMA_ADDR_W,
    parameter int NAB = UMA_ADDR_BY,
    parameter int NDB = UMA_DATA_BY,
    parameter int NCS = UMA_NUM_CS,
    localparam int DIW = $clog2(NDB)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [AW-1:0]         addr,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    input  logic                  busy,
    input  logic                  cap_en,
    input  logic [DIW-1:0]        cap_idx,
    input  logic [7:0]            cap_byte,
    output logic                  start,
    output logic [7:0]            opc,
    output logic [NAB-1:0][7:0]   ab,
    output logic [NDB-1:0][7:0]   db,
    output logic [1:0]            cfg_sel,
    output logic                  cfg_wr,
    output logic                  cfg_addr_en,
    output logic [2:0]            cfg_cnt,
    output logic [NCS-1:0]        hold_n
);

    localparam logic [AW-1:0] A_OPC  = AW'(REG_OPC);
    localparam logic [AW-1:0] A_CTRL = AW'(REG_CTRL);
    localparam logic [AW-1:0] A_HOLD = AW'(REG_HOLD);

    uma_ctrl_t ctrl_q;
    logic      wr_ok;

    assign wr_ok = we && !busy;
    assign start = wr_ok && (addr == A_CTRL) && wdata[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            opc    <= '0;
            ab     <= '0;
            db     <= '0;
            ctrl_q <= '0;
            hold_n <= '1;
        end else begin
            if (wr_ok && addr == A_OPC) opc <= wdata;
            for (int i = 0; i < NAB; i++)
                if (wr_ok && addr == AW'(REG_AB0 + i)) ab[i] <= wdata;
            for (int i = 0; i < NDB; i++)
                if (wr_ok && addr == AW'(REG_DB0 + i)) db[i] <= wdata;
            if (wr_ok && addr == A_CTRL) ctrl_q <= uma_ctrl_t'({1'b0, wdata[6:0]});
            if (we && addr == A_HOLD) hold_n <= wdata[NCS-1:0];
            if (cap_en) db[cap_idx] <= cap_byte;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_OPC) rdata = opc;
        for (int i = 0; i < NAB; i++)
            if (addr == AW'(REG_AB0 + i)) rdata = ab[i];
        for (int i = 0; i < NDB; i++)
            if (addr == AW'(REG_DB0 + i)) rdata = db[i];
        if (addr == A_CTRL)
            rdata = {busy, ctrl_q.sel, ctrl_q.wr, ctrl_q.addr_en, ctrl_q.cnt};
        if (addr == A_HOLD) rdata[NCS-1:0] = hold_n;
    end

    assign cfg_sel     = ctrl_q.sel;
    assign cfg_wr      = ctrl_q.wr;
    assign cfg_addr_en = ctrl_q.addr_en;
    assign cfg_cnt     = ctrl_q.cnt;

endmodule

// File: rtl/uma_seq.sv
module uma_seq
    import spi_uma_pkg::*;
#(
    parameter int NAB = UMA_ADDR_BY,
    parameter int NDB = UMA_DATA_BY,
    localparam int DIW = $clog2(NDB),
    localparam int AIW = $clog2(NAB),
    localparam int IW  = $clog2(NAB + NDB + 3)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [7:0]           opc,
    input  logic [NAB-1:0][7:0]  ab,
    input  logic [NDB-1:0][7:0]  db,
    input  logic                 cfg_wr,
    input  logic                 cfg_addr_en,
    input  logic [2:0]           cfg_cnt,
    input  logic                 miso,
    output logic                 busy,
    output logic                 sck,
    output logic                 mosi,
    output logic                 cap_en,
    output logic [DIW-1:0]       cap_idx,
    output logic [7:0]           cap_byte
);

    uma_phase_t     phase;
    logic [IW-1:0]  byte_idx;
    logic [2:0]     bit_idx;
    logic           sck_q;
    logic           mosi_q;
    logic [7:0]     rx;

    logic [IW-1:0]  n_addr, n_dummy, n_data, last_idx;
    logic [7:0]     cur_tx, nxt_tx;
    logic           cur_is_data;

    // Byte at position idx of the outgoing stream.
    function automatic logic [7:0] tx_byte(
        input logic [IW-1:0]        idx,
        input logic [IW-1:0]        na,
        input logic [IW-1:0]        nd,
        input logic                 wr_mode,
        input logic [7:0]           op,
        input logic [NAB-1:0][7:0]  abv,
        input logic [NDB-1:0][7:0]  dbv
    );
        logic [AIW-1:0] ai;
        logic [DIW-1:0] di;
        ai = AIW'(na - idx);
        di = DIW'(idx - na - nd - IW'(1));
        if (idx == '0)            return op;
        else if (idx <= na)       return abv[ai];
        else if (idx <= na + nd)  return 8'h00;
        else                      return wr_mode ? dbv[di] : 8'h00;
    endfunction

    always_comb begin
        n_addr      = cfg_addr_en ? IW'(NAB) : '0;
        n_dummy     = (opc == OPC_FAST_READ) ? IW'(1) : '0;
        n_data      = IW'(eff_count(cfg_cnt, 3'(NDB)));
        last_idx    = n_addr + n_dummy + n_data;
        cur_tx      = tx_byte(byte_idx, n_addr, n_dummy, cfg_wr, opc, ab, db);
        nxt_tx      = tx_byte(byte_idx + IW'(1), n_addr, n_dummy, cfg_wr, opc, ab, db);
        cur_is_data = byte_idx > (n_addr + n_dummy);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            byte_idx <= '0;
            bit_idx  <= '0;
            sck_q    <= 1'b0;
            mosi_q   <= 1'b0;
            rx       <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    phase    <= PH_SHIFT;
                    byte_idx <= '0;
                    bit_idx  <= 3'd7;
                    sck_q    <= 1'b0;
                    mosi_q   <= opc[7];
                    rx       <= '0;
                end
                PH_SHIFT: begin
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                        rx    <= {rx[6:0], miso};
                    end else begin
                        sck_q <= 1'b0;
                        if (bit_idx == 3'd0) begin
                            if (byte_idx == last_idx) begin
                                phase  <= PH_TAIL;
                                mosi_q <= 1'b0;
                            end else begin
                                byte_idx <= byte_idx + IW'(1);
                                bit_idx  <= 3'd7;
                                mosi_q   <= nxt_tx[7];
                            end
                        end else begin
                            bit_idx <= bit_idx - 3'd1;
                            mosi_q  <= cur_tx[bit_idx - 3'd1];
                        end
                    end
                end
                PH_TAIL: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy     = (phase != PH_IDLE);
    assign sck      = sck_q;
    assign mosi     = mosi_q;
    assign cap_en   = (phase == PH_SHIFT) && sck_q && (bit_idx == 3'd0)
                      && cur_is_data && !cfg_wr;
    assign cap_idx  = DIW'(byte_idx - n_addr - n_dummy - IW'(1));
    assign cap_byte = rx;

endmodule

// File: rtl/uma_csel.sv
module uma_csel
    import spi_uma_pkg::*;
#(
    parameter int NCS = UMA_NUM_CS
) (
    input  logic            busy,
    input  logic [1:0]      sel,
    input  logic [NCS-1:0]  hold_n,
    output logic [NCS-1:0]  cs_n
);

    for (genvar g = 0; g < NCS; g++) begin : g_cs
        logic act;
        assign act     = busy && (sel == 2'(g));
        assign cs_n[g] = hold_n[g] && !act;
    end

endmodule

// File: rtl/spi_uma_engine.sv
module spi_uma_engine
    import spi_uma_pkg::*;
#(
    parameter int AW  = UMA_ADDR_W,
    parameter int NCS = UMA_NUM_CS,
    parameter int NAB = UMA_ADDR_BY,
    parameter int NDB = UMA_DATA_BY
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [AW-1:0]   reg_addr,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    input  logic            miso,
    output logic            sck,
    output logic            mosi,
    output logic [NCS-1:0]  cs_n
);

    localparam int DIW = $clog2(NDB);

    logic                 busy, start, cap_en;
    logic [DIW-1:0]       cap_idx;
    logic [7:0]           cap_byte, opc;
    logic [NAB-1:0][7:0]  ab;
    logic [NDB-1:0][7:0]  db;
    logic [1:0]           cfg_sel;
    logic                 cfg_wr, cfg_addr_en;
    logic [2:0]           cfg_cnt;
    logic [NCS-1:0]       hold_n;

    uma_regs #(.AW(AW), .NAB(NAB), .NDB(NDB), .NCS(NCS)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .busy(busy), .cap_en(cap_en), .cap_idx(cap_idx),
        .cap_byte(cap_byte), .start(start), .opc(opc), .ab(ab), .db(db),
        .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_addr_en(cfg_addr_en),
        .cfg_cnt(cfg_cnt), .hold_n(hold_n)
    );

    uma_seq #(.NAB(NAB), .NDB(NDB)) u_seq (
        .clk(clk), .rst(rst), .start(start), .opc(opc), .ab(ab), .db(db),
        .cfg_wr(cfg_wr), .cfg_addr_en(cfg_addr_en), .cfg_cnt(cfg_cnt),
        .miso(miso), .busy(busy), .sck(sck), .mosi(mosi), .cap_en(cap_en),
        .cap_idx(cap_idx), .cap_byte(cap_byte)
    );

    uma_csel #(.NCS(NCS)) u_csel (
        .busy(busy), .sel(cfg_sel), .hold_n(hold_n), .cs_n(cs_n)
    );

endmodule

// File: rtl/uma_checker.sv
module uma_checker
    import spi_uma_pkg::*;
#(
    parameter int AW  = UMA_ADDR_W,
    parameter int NCS = UMA_NUM_CS,
    parameter int NAB = UMA_ADDR_BY,
    parameter int NDB = UMA_DATA_BY
) (
    input logic            clk,
    input logic            rst,
    input logic            reg_we,
    input logic [AW-1:0]   reg_addr,
    input logic            wr_go,
    input logic            busy,
    input logic            sck,
    input logic            mosi,
    input logic [NCS-1:0]  cs_n,
    input logic [NCS-1:0]  hold_n,
    input logic [7:0]      opc
);

    localparam int MAX_BUSY = 16 * (1 + NAB + 1 + NDB) + 1;

    logic [15:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst)       busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 16'd1;
        else           busy_cnt <= '0;
    end

    a_r11_idle_sck_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sck);

    a_r11_sck_toggles: assert property (@(posedge clk) disable iff (rst)
        (busy && sck) |=> !sck);

    a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == AW'(REG_CTRL) && wr_go && !busy) |=> busy);

    a_r3_busy_bounded: assert property (@(posedge clk) disable iff (rst)
        busy_cnt <= 16'(MAX_BUSY));

    a_r4_mosi_steady_at_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(sck) |-> $stable(mosi));

    a_r8_one_engine_cs: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n & hold_n) <= 1);

    a_r10_opcode_frozen: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> $stable(opc));

endmodule

bind spi_uma_engine uma_checker #(.AW(AW), .NCS(NCS), .NAB(NAB), .NDB(NDB)) u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .wr_go(reg_wdata[7]), .busy(busy), .sck(sck), .mosi(mosi), .cs_n(cs_n),
    .hold_n(hold_n), .opc(opc)
);

// File: tb/sim_spi_uma_engine.sv
module sim_spi_uma_engine;

    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] A_OPC  = 5'h16;
    localparam logic [4:0] A_AB0  = 5'h17;
    localparam logic [4:0] A_DB0  = 5'h1A;
    localparam logic [4:0] A_CTRL = 5'h1E;
    localparam logic [4:0] A_HOLD = 5'h1F;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       miso = 1'b0;
    logic       sck, mosi;
    logic [3:0] cs_n;

    int n_tests = 0;
    int n_fail  = 0;

    spi_uma_engine u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .miso(miso),
        .sck(sck), .mosi(mosi), .cs_n(cs_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Shadow copies of what software wrote
    logic [7:0] sh_opc;
    logic [7:0] sh_ab [3];
    logic [7:0] sh_db [4];

    // Expected stream
    logic [7:0] exp_b [16];
    int         exp_n, data_pos, data_cnt;
    logic       exp_rd;
    logic [7:0] exp_ctrl;

    // Monitor state
    logic       mon_on = 1'b0;
    int         mon_sel = 0;
    logic [3:0] mon_ign = 4'b0000;
    logic       bits [128];
    int         nbits, lowcnt, first_low, first_rise, last_fall, cs_rise;
    int         other_low, double_high, cyc = 0;
    logic       prev_sck;

    function automatic logic [7:0] resp_byte(input int k);
        return 8'hC3 ^ 8'(k * 29);
    endfunction

    function automatic logic resp_bit(input int n);
        logic [7:0] b;
        b = resp_byte(n / 8);
        return b[7 - (n % 8)];
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            if (!cs_n[mon_sel]) begin
                lowcnt++;
                if (first_low < 0) first_low = cyc;
            end else if (first_low >= 0 && cs_rise < 0) begin
                cs_rise = cyc;
            end
            for (int i = 0; i < 4; i++)
                if (i != mon_sel && !cs_n[i] && !mon_ign[i]) other_low++;
            if (sck && !prev_sck) begin
                if (nbits < 128) bits[nbits] = mosi;
                nbits++;
                if (first_rise < 0) first_rise = cyc;
            end
            if (!sck && prev_sck) last_fall = cyc;
            if (sck && prev_sck) double_high++;
            prev_sck = sck;
            if (!sck) miso = resp_bit(nbits);
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_regs(input logic [7:0] op, input logic [7:0] a0, a1, a2,
                            input logic [7:0] d0, d1, d2, d3);
        bus_write(A_OPC, op);       sh_opc = op;
        bus_write(A_AB0, a0);       sh_ab[0] = a0;
        bus_write(A_AB0 + 5'd1, a1); sh_ab[1] = a1;
        bus_write(A_AB0 + 5'd2, a2); sh_ab[2] = a2;
        bus_write(A_DB0, d0);       sh_db[0] = d0;
        bus_write(A_DB0 + 5'd1, d1); sh_db[1] = d1;
        bus_write(A_DB0 + 5'd2, d2); sh_db[2] = d2;
        bus_write(A_DB0 + 5'd3, d3); sh_db[3] = d3;
    endtask

    task automatic begin_xfer(input logic [7:0] ctrl, input logic [3:0] ign);
        int cnt;
        cnt      = (ctrl[2:0] > 3'd4) ? 4 : int'(ctrl[2:0]);
        exp_rd   = !ctrl[4];
        exp_ctrl = {1'b0, ctrl[6:0]};
        exp_n    = 0;
        exp_b[exp_n++] = sh_opc;
        if (ctrl[3]) begin
            exp_b[exp_n++] = sh_ab[2];
            exp_b[exp_n++] = sh_ab[1];
            exp_b[exp_n++] = sh_ab[0];
        end
        if (sh_opc == 8'h0B) exp_b[exp_n++] = 8'h00;
        data_pos = exp_n;
        data_cnt = cnt;
        for (int d = 0; d < cnt; d++) exp_b[exp_n++] = ctrl[4] ? sh_db[d] : 8'h00;
        nbits = 0; lowcnt = 0; first_low = -1; first_rise = -1; last_fall = -1;
        cs_rise = -1; other_low = 0; double_high = 0; prev_sck = 1'b0;
        mon_sel = int'(ctrl[6:5]); mon_ign = ign; mon_on = 1'b1;
        bus_write(A_CTRL, ctrl | 8'h80);
    endtask

    task automatic finish_xfer(input logic held, input string req);
        logic [7:0] st, got;
        int polls, bad;
        polls = 0;
        do begin
            bus_read(A_CTRL, st);
            polls++;
        end while (st[7] && polls < 400);
        chk(!st[7], "R3", {req, " busy flag cleared"}, st, exp_ctrl);
        chk(st == exp_ctrl, "R3", {req, " control fields kept"}, st, exp_ctrl);
        @(negedge clk);
        mon_on = 1'b0;
        chk(nbits == 8 * exp_n, "R11", {req, " rising edge count"}, nbits, 8 * exp_n);
        bad = 0;
        for (int k = 0; k < exp_n && 8 * k + 7 < 128; k++) begin
            for (int b = 0; b < 8; b++) got[7 - b] = bits[8 * k + b];
            if (got !== exp_b[k]) begin
                bad++;
                $display("FAIL R4 %s byte %0d actual=0x%0h expected=0x%0h", req, k, got, exp_b[k]);
            end
        end
        n_tests++;
        if (bad != 0) n_fail++;
        if (!held) begin
            chk(lowcnt == 16 * exp_n + 1, "R3", {req, " busy cycles"}, lowcnt, 16 * exp_n + 1);
            chk(first_rise == first_low + 1, "R8", {req, " cs lead"}, first_rise - first_low, 1);
            chk(cs_rise == last_fall + 1, "R8", {req, " cs tail"}, cs_rise - last_fall, 1);
        end
        chk(other_low == 0, "R8", {req, " other cs low"}, other_low, 0);
        chk(double_high == 0, "R11", {req, " sck toggles"}, double_high, 0);
        if (exp_rd) begin
            for (int d = 0; d < 4; d++) begin
                logic [7:0] v, e;
                bus_read(A_DB0 + 5'(d), v);
                e = (d < data_cnt) ? resp_byte(data_pos + d) : sh_db[d];
                chk(v == e, "R5", {req, " read data"}, v, e);
                sh_db[d] = e;
            end
        end
    endtask

    task automatic t_reset;
        logic [7:0] v;
        bus_read(A_CTRL, v);
        chk(v == 8'h00, "R1", "control after reset", v, 0);
        bus_read(A_HOLD, v);
        chk(v == 8'h0F, "R1", "hold after reset", v, 8'h0F);
        chk(cs_n == 4'hF && !sck && !mosi, "R1", "pins after reset",
            {cs_n, sck, mosi}, 8'h3C);
    endtask

    task automatic t_regmap;
        logic [7:0] v;
        set_regs(8'h03, 8'h11, 8'h22, 8'h33, 8'hDE, 8'hAD, 8'hBE, 8'hEF);
        bus_read(A_OPC, v);          chk(v == 8'h03, "R2", "opcode readback", v, 8'h03);
        bus_read(A_AB0, v);          chk(v == 8'h11, "R2", "addr0 readback", v, 8'h11);
        bus_read(A_AB0 + 5'd2, v);   chk(v == 8'h33, "R2", "addr2 readback", v, 8'h33);
        bus_read(A_DB0, v);          chk(v == 8'hDE, "R2", "data0 readback", v, 8'hDE);
        bus_read(A_DB0 + 5'd3, v);   chk(v == 8'hEF, "R2", "data3 readback", v, 8'hEF);
        bus_write(A_CTRL, 8'h5A);
        bus_read(A_CTRL, v);         chk(v == 8'h5A, "R2", "control readback", v, 8'h5A);
    endtask

    task automatic t_write_xfer;
        bus_write(A_OPC, 8'h02); sh_opc = 8'h02;
        begin_xfer(8'h3C, 4'b0000);          // addr, write, cs1, 4 bytes
        finish_xfer(1'b0, "R5 write");
    endtask

    task automatic t_read_xfer;
        bus_write(A_OPC, 8'h03); sh_opc = 8'h03;
        begin_xfer(8'h4B, 4'b0000);          // addr, read, cs2, 3 bytes
        finish_xfer(1'b0, "R5 read");
    endtask

    task automatic t_fast_read;
        bus_write(A_OPC, 8'h0B); sh_opc = 8'h0B;
        begin_xfer(8'h0A, 4'b0000);          // addr, read, cs0, 2 bytes
        finish_xfer(1'b0, "R6 fast read");
    endtask

    task automatic t_counts;
        bus_write(A_OPC, 8'h9F); sh_opc = 8'h9F;
        begin_xfer(8'h67, 4'b0000);          // no addr, read, cs3, count 7
        finish_xfer(1'b0, "R7 count7");
        bus_write(A_OPC, 8'h06); sh_opc = 8'h06;
        begin_xfer(8'h10, 4'b0000);          // no addr, write, cs0, count 0
        finish_xfer(1'b0, "R7 count0");
    endtask

    task automatic t_busy_ignore;
        logic [7:0] v;
        set_regs(8'h20, 8'h44, 8'h55, 8'h66, 8'h01, 8'h02, 8'h03, 8'h04);
        begin_xfer(8'h1C, 4'b1000);          // addr, write, cs0, 4 bytes
        bus_write(A_OPC, 8'h55);
        bus_write(A_DB0, 8'h99);
        bus_write(A_AB0, 8'h77);
        bus_write(A_CTRL, 8'h83);
        bus_write(A_HOLD, 8'hF7);
        finish_xfer(1'b0, "R10 busy writes");
        bus_read(A_OPC, v);  chk(v == 8'h20, "R10", "opcode kept", v, 8'h20);
        bus_read(A_DB0, v);  chk(v == 8'h01, "R10", "data0 kept", v, 8'h01);
        bus_read(A_AB0, v);  chk(v == 8'h44, "R10", "addr0 kept", v, 8'h44);
        bus_read(A_HOLD, v); chk(v == 8'h07, "R10", "hold written while busy", v, 8'h07);
        chk(cs_n == 4'b0111, "R10", "held cs3 low", cs_n, 4'b0111);
        bus_write(A_HOLD, 8'h0F);
    endtask

    task automatic t_hold;
        logic [7:0] v;
        bus_write(A_HOLD, 8'hFD);
        bus_read(A_HOLD, v); chk(v == 8'h0D, "R9", "hold upper bits read 0", v, 8'h0D);
        chk(cs_n == 4'b1101, "R9", "idle held cs1", cs_n, 4'b1101);
        bus_write(A_OPC, 8'h05); sh_opc = 8'h05;
        begin_xfer(8'h21, 4'b0000);          // no addr, read, cs1, 1 byte
        finish_xfer(1'b1, "R9 held");
        chk(cs_n == 4'b1101, "R9", "cs1 stays low after", cs_n, 4'b1101);
        bus_write(A_HOLD, 8'hFF);
        bus_read(A_HOLD, v); chk(v == 8'h0F, "R9", "hold release", v, 8'h0F);
        chk(cs_n == 4'hF, "R9", "all cs high", cs_n, 4'hF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_write_xfer();
        t_read_xfer();
        t_fast_read();
        t_counts();
        t_busy_ignore();
        t_hold();
        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL R3 watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule